// File: doc/BRIEF.md
# Lenient Predicated Dataflow Merge

This block joins the two arms of an if/else that a dataflow pipeline has evaluated speculatively. Both arm results arrive on their own channels, and a one-bit predicate from a comparison says which one is the real result. The node computes nothing. It forwards the chosen value unchanged, and it makes sure that the other value is consumed exactly once, so later iterations stay aligned.

Every channel uses a clocked valid/acknowledge handshake. A producer asserts valid with its data and holds both until it sees acknowledge high in a cycle; the token moves at that clock edge. The merge is lenient. It offers a result as soon as the predicate and the chosen operand are present, and it does not wait for the arm that lost. A slow losing arm therefore does not delay the result. When the losing token is still missing at the moment of firing, a per-side drop counter records the debt. The late token is then acknowledged on arrival and thrown away. A counter that is already full blocks any predicate that would add to it.

Top module: `lenient_select_merge`

## Requirements
- R1: After reset, `y_valid` and all input acknowledges are 0 while no input is valid, and both drop counters are empty.
- R2: `sel_bit` = 1 selects channel A and `sel_bit` = 0 selects channel B. `y_data` is a bit-exact copy of the selected channel's data.
- R3: `y_valid` is asserted whenever `sel_valid` and the selected channel's live token are present, even if the other channel has no token.
- R4: `sel_ack` and the selected channel's ack are high in exactly the cycles where `y_valid` and `y_ack` are both high, and never otherwise.
- R5: While `y_valid` is high and `y_ack` is low, `y_valid` stays high and `y_data` stays unchanged in the next cycle.
- R6: If the unselected channel holds a live token when the node fires, that token is acknowledged in the same cycle.
- R7: If the unselected token is missing at firing, the next token to arrive on that channel is acknowledged without reaching the output. The next firing that selects that channel uses the token after it.
- R8: With `DISCARD_MAX` drops pending on one channel, a predicate that would leave that channel unselected is not acknowledged and produces no output until a drop occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_data | input | DATA_W | Channel A (then-arm) data |
| a_valid | input | 1 | Channel A token present |
| a_ack | output | 1 | Channel A token taken or dropped |
| b_data | input | DATA_W | Channel B (else-arm) data |
| b_valid | input | 1 | Channel B token present |
| b_ack | output | 1 | Channel B token taken or dropped |
| sel_bit | input | 1 | Predicate: 1 picks A, 0 picks B |
| sel_valid | input | 1 | Predicate token present |
| sel_ack | output | 1 | Predicate token taken |
| y_data | output | DATA_W | Merged result |
| y_valid | output | 1 | Result token present |
| y_ack | input | 1 | Downstream takes the result |

## Verification
The bound checker checks on every cycle that the output is held until it is taken and that the output data follows the selected channel. It also checks that the predicate and the chosen operand are acknowledged only together with the output transfer, and that a full drop counter blocks the predicate. Only the bench scenarios can show what happens across tokens. They show that a late losing token is dropped and does not pair with a later iteration, and that every losing token is eventually consumed. Randomly delayed arms that compute -x and b*x produce the right result stream for each x.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    // Which arm a predicate picks; the value equals the predicate bit.
    typedef enum logic {
        ARM_ELSE = 1'b0,
        ARM_THEN = 1'b1
    } arm_e;

    // Next value of a drop counter given one increment and one decrement.
    function automatic int unsigned drop_next(int unsigned cur, logic inc, logic dec);
        int unsigned n;
        n = cur;
        if (inc) n = n + 1;
        if (dec) n = n - 1;
        return n;
    endfunction

endpackage

// File: rtl/lsm_drop_track.sv
module lsm_drop_track #(
    parameter int DISCARD_MAX = 3,
    localparam int CNT_W = $clog2(DISCARD_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic fire,
    input  logic is_sel,
    output logic live,
    output logic full,
    output logic ack
);
    logic [CNT_W-1:0] cnt_q;
    logic             owed;
    logic             drop;
    logic             inc;

    assign owed = (cnt_q != '0);
    assign live = in_valid && !owed;
    assign drop = in_valid && owed;
    assign full = (cnt_q == CNT_W'(DISCARD_MAX));
    assign inc  = fire && !is_sel && !live;
    assign ack  = drop || (fire && is_sel) || (fire && !is_sel && live);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= CNT_W'(lsm_pkg::drop_next(32'(cnt_q), inc, drop));
        end
    end
endmodule

// File: rtl/lsm_fire_ctl.sv
module lsm_fire_ctl (
    input  logic       sel_valid,
    input  logic       sel_bit,
    input  logic [1:0] live,
    input  logic [1:0] full,
    input  logic       y_ack,
    output logic       y_valid,
    output logic       fire,
    output logic [1:0] is_sel
);
    import lsm_pkg::*;
    arm_e pick;
    arm_e other;

    always_comb begin
        pick      = arm_e'(sel_bit);
        other     = arm_e'(!sel_bit);
        is_sel    = '0;
        is_sel[pick] = 1'b1;
        y_valid   = sel_valid && live[pick] && !full[other];
        fire      = y_valid && y_ack;
    end
endmodule

// File: rtl/lenient_select_merge.sv
module lenient_select_merge #(
    parameter int DATA_W      = 16,
    parameter int DISCARD_MAX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_valid,
    output logic              a_ack,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_valid,
    output logic              b_ack,
    input  logic              sel_bit,
    input  logic              sel_valid,
    output logic              sel_ack,
    output logic [DATA_W-1:0] y_data,
    output logic              y_valid,
    input  logic              y_ack
);
    localparam int N_ARMS = 2;

    logic [N_ARMS-1:0] arm_valid;
    logic [N_ARMS-1:0] arm_live;
    logic [N_ARMS-1:0] arm_full;
    logic [N_ARMS-1:0] arm_ack;
    logic [N_ARMS-1:0] arm_sel;
    logic              fire;

    // index 1 = then-arm (A), index 0 = else-arm (B)
    assign arm_valid = {a_valid, b_valid};

    lsm_fire_ctl u_ctl (
        .sel_valid (sel_valid),
        .sel_bit   (sel_bit),
        .live      (arm_live),
        .full      (arm_full),
        .y_ack     (y_ack),
        .y_valid   (y_valid),
        .fire      (fire),
        .is_sel    (arm_sel)
    );

    for (genvar g = 0; g < N_ARMS; g++) begin : g_arm
        lsm_drop_track #(.DISCARD_MAX(DISCARD_MAX)) u_trk (
            .clk      (clk),
            .rst      (rst),
            .in_valid (arm_valid[g]),
            .fire     (fire),
            .is_sel   (arm_sel[g]),
            .live     (arm_live[g]),
            .full     (arm_full[g]),
            .ack      (arm_ack[g])
        );
    end

    assign a_ack   = arm_ack[1];
    assign b_ack   = arm_ack[0];
    assign sel_ack = fire;
    assign y_data  = sel_bit ? a_data : b_data;
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_data,
    input logic [DATA_W-1:0] b_data,
    input logic              a_ack,
    input logic              b_ack,
    input logic              sel_bit,
    input logic              sel_valid,
    input logic              sel_ack,
    input logic [DATA_W-1:0] y_data,
    input logic              y_valid,
    input logic              y_ack,
    input logic              a_full,
    input logic              b_full
);
    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !(y_valid && !sel_valid)); // R1
    AST_PICK_THEN: assert property (@(posedge clk) disable iff (rst) (y_valid && sel_bit) |-> (y_data == a_data)); // R2
    AST_PICK_ELSE: assert property (@(posedge clk) disable iff (rst) (y_valid && !sel_bit) |-> (y_data == b_data)); // R2
    AST_ACK_WITH_XFER: assert property (@(posedge clk) disable iff (rst) sel_ack |-> (y_valid && y_ack)); // R4
    AST_XFER_ACKS: assert property (@(posedge clk) disable iff (rst) (y_valid && y_ack) |-> (sel_ack && (sel_bit ? a_ack : b_ack))); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (y_valid && !y_ack) |=> (y_valid && $stable(y_data))); // R5
    AST_NO_OVERFLOW_B: assert property (@(posedge clk) disable iff (rst) (sel_valid && sel_bit && b_full) |-> !sel_ack); // R8
    AST_NO_OVERFLOW_A: assert property (@(posedge clk) disable iff (rst) (sel_valid && !sel_bit && a_full) |-> !sel_ack); // R8
endmodule

bind lenient_select_merge lsm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_data    (a_data),
    .b_data    (b_data),
    .a_ack     (a_ack),
    .b_ack     (b_ack),
    .sel_bit   (sel_bit),
    .sel_valid (sel_valid),
    .sel_ack   (sel_ack),
    .y_data    (y_data),
    .y_valid   (y_valid),
    .y_ack     (y_ack),
    .a_full    (arm_full[1]),
    .b_full    (arm_full[0])
);

// File: tb/test_lenient_select_merge.sv
module test_lenient_select_merge;
    localparam int DW = 16;
    localparam int NTOK = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] a_data = '0, b_data = '0, y_data;
    logic          a_valid = 0, b_valid = 0, sel_bit = 0, sel_valid = 0, y_ack = 0;
    logic          a_ack, b_ack, sel_ack, y_valid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk; // 125 MHz

    lenient_select_merge #(.DATA_W(DW), .DISCARD_MAX(3)) i_lenient_select_merge (
        .clk(clk), .rst(rst),
        .a_data(a_data), .a_valid(a_valid), .a_ack(a_ack),
        .b_data(b_data), .b_valid(b_valid), .b_ack(b_ack),
        .sel_bit(sel_bit), .sel_valid(sel_valid), .sel_ack(sel_ack),
        .y_data(y_data), .y_valid(y_valid), .y_ack(y_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Wrapper arithmetic for the if/else being merged
    function automatic logic [DW-1:0] then_val(int x);
        return DW'(-x);
    endfunction
    function automatic logic [DW-1:0] else_val(int x, int b);
        return DW'(b * x);
    endfunction

    int xs [NTOK];
    int bs [NTOK];

    task automatic put_a(input logic [DW-1:0] v);
        bit got;
        a_data = v; a_valid = 1;
        forever begin
            @(negedge clk); got = a_ack;
            @(posedge clk); #1;
            if (got) break;
        end
        a_valid = 0;
    endtask

    task automatic put_b(input logic [DW-1:0] v);
        bit got;
        b_data = v; b_valid = 1;
        forever begin
            @(negedge clk); got = b_ack;
            @(posedge clk); #1;
            if (got) break;
        end
        b_valid = 0;
    endtask

    task automatic put_p(input logic v);
        bit got;
        sel_bit = v; sel_valid = 1;
        forever begin
            @(negedge clk); got = sel_ack;
            @(posedge clk); #1;
            if (got) break;
        end
        sel_valid = 0;
    endtask

    task automatic do_reset();
        rst = 1; a_valid = 0; b_valid = 0; sel_valid = 0; y_ack = 0;
        repeat (3) tick();
        rst = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R1: idle after reset
        @(negedge clk);
        check(!y_valid && !a_ack && !b_ack && !sel_ack, "R1 idle after reset", int'(y_valid), 0);

        // R3/R2: then-arm only, else-arm absent
        tick();
        sel_bit = 1; sel_valid = 1; a_data = 16'd5; a_valid = 1; y_ack = 0;
        @(negedge clk);
        check(y_valid == 1, "R3 fires without unselected token", int'(y_valid), 1);
        check(y_data == 16'd5, "R2 then-arm data", int'(y_data), 5);
        check(!sel_ack && !a_ack, "R4 no ack before y_ack", int'(sel_ack), 0);
        tick();
        @(negedge clk);
        check(y_valid && y_data == 16'd5, "R5 output held", int'(y_data), 5);
        tick();
        y_ack = 1;
        @(negedge clk);
        check(sel_ack && a_ack && !b_ack, "R4 acks with transfer", int'({sel_ack, a_ack, b_ack}), 6);
        tick();
        sel_valid = 0; a_valid = 0; y_ack = 0;

        // R7: late else token dropped, never output
        b_data = 16'd77; b_valid = 1;
        @(negedge clk);
        check(b_ack == 1, "R7 late token dropped", int'(b_ack), 1);
        check(y_valid == 0, "R7 dropped token not output", int'(y_valid), 0);
        tick();
        b_valid = 0;

        // R8: three firings fill the else-arm drop counter
        sel_bit = 1; sel_valid = 1; a_data = 16'd9; a_valid = 1; y_ack = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(y_valid && sel_ack, "R8 fires below limit", int'(y_valid), 1);
            tick();
        end
        @(negedge clk);
        check(!y_valid && !sel_ack, "R8 blocked at limit", int'(sel_ack), 0);
        tick();
        b_data = 16'd1; b_valid = 1;
        @(negedge clk);
        check(b_ack && !sel_ack, "R8 drop while blocked", int'(b_ack), 1);
        tick();
        b_valid = 0;
        @(negedge clk);
        check(y_valid && sel_ack, "R8 resumes after drop", int'(y_valid), 1);
        tick();
        sel_valid = 0; a_valid = 0; y_ack = 0;

        // R6: both present, else selected, then token consumed together
        do_reset();
        sel_bit = 0; sel_valid = 1; a_data = 16'd4; a_valid = 1; b_data = 16'd9; b_valid = 1; y_ack = 1;
        @(negedge clk);
        check(y_data == 16'd9, "R2 else-arm data", int'(y_data), 9);
        check(a_ack && b_ack && sel_ack, "R6 unselected consumed same cycle", int'({a_ack, b_ack, sel_ack}), 7);
        tick();
        sel_valid = 0; a_valid = 0; b_valid = 0; y_ack = 0;
        do_reset();

        // Random phase: y = -x for x > 0 else y = b*x, random arrival delays
        for (int i = 0; i < NTOK; i++) begin
            xs[i] = int'($urandom_range(200)) - 100;
            bs[i] = int'($urandom_range(200)) - 100;
        end
        fork
            for (int i = 0; i < NTOK; i++) begin
                repeat ($urandom_range(5)) tick();
                put_a(then_val(xs[i]));
            end
            for (int i = 0; i < NTOK; i++) begin
                repeat ($urandom_range(7)) tick();
                put_b(else_val(xs[i], bs[i]));
            end
            for (int i = 0; i < NTOK; i++) begin
                repeat ($urandom_range(3)) tick();
                put_p(xs[i] > 0);
            end
            begin
                int got;
                bit held;
                logic [DW-1:0] held_d;
                logic [DW-1:0] exp;
                got = 0; held = 0; held_d = '0;
                while (got < NTOK) begin
                    @(negedge clk);
                    if (held) check(y_valid && y_data == held_d, "R5 hold under backpressure", int'(y_data), int'(held_d));
                    if (y_valid && y_ack) begin
                        exp = (xs[got] > 0) ? then_val(xs[got]) : else_val(xs[got], bs[got]);
                        check(y_data == exp, "R2 R3 R7 merged result", int'(y_data), int'(exp));
                        got++;
                        held = 0;
                    end else begin
                        held = y_valid;
                        held_d = y_data;
                    end
                    @(posedge clk); #1;
                    y_ack = ($urandom_range(3) != 0);
                end
                y_ack = 0;
            end
        join
        repeat (2) tick();
        @(negedge clk);
        check(!y_valid && !a_valid && !b_valid, "R6 R7 all arm tokens consumed", int'(y_valid), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule